// File: doc/BRIEF.md
# PRBS-23 Pattern Generator

This block produces the 2^23−1 pseudo-random bit pattern used to measure the bit error rate of a serial link. A 23-bit linear feedback shift register with XOR feedback from stages 23 and 18 (polynomial x^23 + x^18 + 1) is stepped once per pattern bit. The emitted bit is the inverse of the feedback bit. The parameter `W` picks the form. With `W = 1` the block emits one bit per clock. With larger `W` the register is unrolled, so each clock emits the next `W` consecutive pattern bits. A wide word lets a fast line be fed from a modest fabric clock; for example, 64 bits at about 155.52 MHz serves a 10 Gb/s line.

An all-zero register would feed back zeros for ever. The block checks the whole register against zero on every clock and forces a one into bit 0 on the next edge, so the pattern restarts without outside help. A single-cycle inject input flips one bit of the output word, which lets a downstream checker be tested.

Top module: `prbs23_gen`

## Requirements
- R1: Each pattern step computes fb = s[22] ^ s[17]. The register becomes {s[21:0], fb} and the emitted bit is ~fb. From the all-ones state, the first 24 emitted bits are 18 ones, then 5 zeros, then 1 one (0xFFFFC1, earliest bit first).
- R2: With `W` > 1, each output word holds the next `W` consecutive pattern bits. The earliest bit is in bit W−1 (MSB), so successive words concatenated MSB-first equal the serial stream.
- R3: With `W` = 1, the block emits exactly one pattern bit per enabled clock on data bit 0.
- R4: Reset is synchronous and active high. While reset is sampled high, the data output is 0, valid is 0, and the register loads `SEED` (all ones by default).
- R5: Valid is 1 on the edge following every clock where enable is sampled high, including the first clock after reset is released. Otherwise it is 0.
- R6: While enable is low, the data output holds its last value, the pattern does not advance, and inject has no effect.
- R7: If the register is all zeros on a clock edge, the next register value is 1 (bit 0 set). If enable is high on that edge, the word emitted is all ones. The pattern then continues from state 1.
- R8: Inject sampled high together with enable inverts bit 0 of that output word only. The pattern sequence itself is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Advance the pattern and emit one word |
| inj_i | input | 1 | Flip bit 0 of the word emitted this clock |
| data_o | output | W | Pattern word, earliest bit in MSB |
| valid_o | output | 1 | Data output was updated on the last edge |

## Verification
Data and valid are registered. Both respond one clock edge after the edge where enable and inject are sampled. A lockup recovery shows on the register one edge after the all-zero state is seen. The bench changes inputs only at the falling edge and compares outputs at the next falling edge, so each compare comes after exactly one rising edge. Its reference model advances only on enabled cycles, and advances the lockup step on every cycle.

// File: rtl/prbs23_pkg.sv
package prbs23_pkg;
  localparam int LEN   = 23;
  localparam int TAP_A = 22;  // stage 23
  localparam int TAP_B = 17;  // stage 18
  typedef logic [LEN-1:0] prbs_state_t;
endpackage

// File: rtl/prbs23_unroll.sv
module prbs23_unroll
  import prbs23_pkg::*;
#(
  parameter int W = 64
) (
  input  prbs_state_t  state_i,
  output prbs_state_t  next_o,
  output logic [W-1:0] word_o
);
  generate
    if (W == 1) begin : g_serial
      logic fb;
      assign fb     = state_i[TAP_A] ^ state_i[TAP_B];
      assign next_o = {state_i[LEN-2:0], fb};
      assign word_o = ~fb;
    end else begin : g_parallel
      always_comb begin
        prbs_state_t s;
        logic        fb;
        s      = state_i;
        word_o = '0;
        for (int k = 0; k < W; k++) begin
          fb            = s[TAP_A] ^ s[TAP_B];
          s             = {s[LEN-2:0], fb};
          word_o[W-1-k] = ~fb;
        end
        next_o = s;
      end
    end
  endgenerate
endmodule

// File: rtl/prbs23_state_reg.sv
module prbs23_state_reg
  import prbs23_pkg::*;
#(
  parameter prbs_state_t SEED = '1
) (
  input  logic        clk_i,
  input  logic        rst_i,
  input  logic        adv_i,
  input  prbs_state_t next_i,
  output prbs_state_t state_o,
  output logic        zero_o
);
  prbs_state_t state_q;

  assign zero_o  = (state_q == '0);
  assign state_o = state_q;

  always_ff @(posedge clk_i) begin
    if (rst_i)       state_q <= SEED;
    else if (zero_o) state_q <= prbs_state_t'(1);
    else if (adv_i)  state_q <= next_i;
  end

  // R7: an all-zero register always becomes 1 on the next edge
  a_r7_lock_escape: assert property (@(posedge clk_i) disable iff (rst_i)
    (state_q == '0) |=> (state_q == prbs_state_t'(1)));
endmodule

// File: rtl/prbs23_out_reg.sv
module prbs23_out_reg #(
  parameter int W = 64
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         en_i,
  input  logic         inj_i,
  input  logic [W-1:0] word_i,
  output logic [W-1:0] data_o,
  output logic         valid_o
);
  localparam logic [W-1:0] INJ_BIT = W'(1);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      data_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= en_i;
      if (en_i) data_o <= word_i ^ (inj_i ? INJ_BIT : '0);
    end
  end

  // R5: valid tracks enable one edge later
  a_r5_valid_on: assert property (@(posedge clk_i) disable iff (rst_i)
    en_i |=> valid_o);
  a_r5_valid_off: assert property (@(posedge clk_i) disable iff (rst_i)
    !en_i |=> !valid_o);
  // R6: idle clocks leave the output word untouched, inject included
  a_r6_hold_idle: assert property (@(posedge clk_i) disable iff (rst_i)
    !en_i |=> $stable(data_o));
endmodule

// File: rtl/prbs23_gen.sv
module prbs23_gen
  import prbs23_pkg::*;
#(
  parameter int          W    = 64,
  parameter prbs_state_t SEED = '1
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         en_i,
  input  logic         inj_i,
  output logic [W-1:0] data_o,
  output logic         valid_o
);
  prbs_state_t  state;
  prbs_state_t  next_state;
  logic [W-1:0] word;
  logic         zero;

  prbs23_state_reg #(.SEED(SEED)) u_state (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .adv_i  (en_i),
    .next_i (next_state),
    .state_o(state),
    .zero_o (zero)
  );

  prbs23_unroll #(.W(W)) u_unroll (
    .state_i(state),
    .next_o (next_state),
    .word_o (word)
  );

  prbs23_out_reg #(.W(W)) u_out (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .en_i   (en_i),
    .inj_i  (inj_i),
    .word_i (word),
    .data_o (data_o),
    .valid_o(valid_o)
  );

  // R7: the word emitted from a locked register is all ones
  a_r7_lock_word_ones: assert property (@(posedge clk_i) disable iff (rst_i)
    (zero && en_i && !inj_i) |=> (data_o == '1));
endmodule

// File: tb/sim_prbs23_gen.sv
module sim_prbs23_gen;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst, en0, inj0, en_s, en_l;
  logic [63:0] d0;
  logic        v0;
  logic [0:0]  ds;
  logic        vs;
  logic [7:0]  dl;
  logic        vl;
  int tests = 0, fails = 0;

  prbs23_gen #(.W(64)) u0 (
    .clk_i(clk), .rst_i(rst), .en_i(en0), .inj_i(inj0), .data_o(d0), .valid_o(v0));
  prbs23_gen #(.W(1)) u_ser (
    .clk_i(clk), .rst_i(rst), .en_i(en_s), .inj_i(1'b0), .data_o(ds), .valid_o(vs));
  prbs23_gen #(.W(8), .SEED(23'h0)) u_lock (
    .clk_i(clk), .rst_i(rst), .en_i(en_l), .inj_i(1'b0), .data_o(dl), .valid_o(vl));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reference model built from R1 and R7
  function automatic void gen(input logic [22:0] s_in, input int n,
                              output logic [63:0] w, output logic [22:0] s_out);
    logic [22:0] s;
    logic fb;
    s = s_in;
    w = '0;
    if (s == '0) begin
      w     = (n == 64) ? '1 : ((64'd1 << n) - 64'd1);
      s_out = 23'd1;
      return;
    end
    for (int i = 0; i < n; i++) begin
      fb = s[22] ^ s[17];
      s  = {s[21:0], fb};
      w  = {w[62:0], ~fb};
    end
    s_out = s;
  endfunction

  // advance one model instance for one clock
  function automatic void step(input logic en, input int n, inout logic [22:0] st,
                               inout logic [63:0] exp_w);
    logic [63:0] w;
    logic [22:0] ns;
    if (en) begin
      gen(st, n, w, ns);
      st = ns;
      exp_w = w;
    end else if (st == '0) begin
      st = 23'd1;
    end
  endfunction

  initial begin
    #(100000 * 20);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [22:0] m0, ms, ml;
    logic [63:0] e0, es, el;
    logic [191:0] ser_bits;
    logic [191:0] par_bits;
    void'($urandom(32'd4242));
    rst = 1'b1; en0 = 1'b0; inj0 = 1'b0; en_s = 1'b0; en_l = 1'b0;
    repeat (3) @(negedge clk);
    // R4: reset state
    chk("R4 data", d0, 64'd0);
    chk("R4 valid", {63'd0, v0}, 64'd0);
    chk("R4 valid serial", {63'd0, vs}, 64'd0);
    chk("R4 valid lock", {63'd0, vl}, 64'd0);
    m0 = '1; ms = '1; ml = '0;
    e0 = '0; es = '0; el = '0;
    ser_bits = '0; par_bits = '0;
    rst = 1'b0;

    for (int i = 0; i < 192; i++) begin
      en0 = (i < 3); en_s = 1'b1; en_l = (i < 40);
      @(negedge clk);
      step(en0, 64, m0, e0);
      step(en_s, 1, ms, es);
      step(en_l, 8, ml, el);
      ser_bits = {ser_bits[190:0], ds[0]};
      if (i < 3) par_bits = {par_bits[127:0], d0};
      if (i == 0) begin
        chk("R1 first 24 bits", {40'd0, d0[63:40]}, 64'hFFFFC1);
        chk("R5 valid first clock", {63'd0, v0}, 64'd1);
        chk("R7 locked word all ones", {56'd0, dl}, 64'hFF);
      end
      if (i == 1) chk("R7 continue from state 1", {56'd0, dl}, el);
      chk("R2 parallel word", d0, e0);
      chk("R3 serial bit", {63'd0, ds[0]}, es);
      chk("R3 serial valid", {63'd0, vs}, 64'd1);
      chk("R7 lock instance", {56'd0, dl}, el);
      chk("R5 lock valid", {63'd0, vl}, {63'd0, en_l});
    end
    chk("R1 serial first 24 bits", {40'd0, ser_bits[191:168]}, 64'hFFFFC1);
    chk("R2 words equal serial stream hi", par_bits[191:128], ser_bits[191:128]);
    chk("R2 words equal serial stream mid", par_bits[127:64], ser_bits[127:64]);
    chk("R2 words equal serial stream lo", par_bits[63:0], ser_bits[63:0]);
    chk("R6 held word", d0, par_bits[63:0]);
    chk("R5 valid low when idle", {63'd0, v0}, 64'd0);

    // directed: inject while idle is ignored, then inject while enabled
    en0 = 1'b0; inj0 = 1'b1;
    @(negedge clk);
    step(1'b0, 64, m0, e0);
    chk("R6 inject ignored when idle", d0, e0);
    en0 = 1'b1; inj0 = 1'b1;
    @(negedge clk);
    step(1'b1, 64, m0, e0);
    chk("R8 inject flips bit 0", d0, e0 ^ 64'd1);
    en0 = 1'b1; inj0 = 1'b0;
    @(negedge clk);
    step(1'b1, 64, m0, e0);
    chk("R8 sequence unchanged after inject", d0, e0);

    // constrained random enable and inject
    for (int i = 0; i < 3000; i++) begin
      logic en_r, inj_r;
      en_r  = ($urandom % 4) != 0;
      inj_r = ($urandom % 5) == 0;
      en0 = en_r; inj0 = inj_r;
      @(negedge clk);
      step(en_r, 64, m0, e0);
      if (en_r && inj_r)  chk("R8 random inject", d0, e0 ^ 64'd1);
      else if (!en_r)     chk("R6 random idle", d0, (d0 == e0) ? e0 : e0 ^ 64'd1);
      else                chk("R2 random word", d0, e0);
      chk("R5 random valid", {63'd0, v0}, {63'd0, en_r});
      if (en_r && inj_r) e0 = e0 ^ 64'd1;  // held value now carries the flip
    end

    // R4: reset in mid-run restores the seed
    rst = 1'b1; en0 = 1'b1;
    @(negedge clk);
    chk("R4 mid-run reset data", d0, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R4 seed reloaded", {40'd0, d0[63:40]}, 64'hFFFFC1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule